// File: doc/BRIEF.md
# Periodic Request Flag Controller

This block raises a periodic request for a real-time clock. A timebase outside the block supplies two strobe buses, one strobe per selectable period. `period_tick[i]` pulses for one cycle each time period `i` expires. `half_tick[i]` pulses for one cycle halfway through that period. A 3-bit period-select field picks one tap. Each time that tap expires, the block sets a request flag and drives an active-low open-drain-style output, unless the mask bit blocks it.

A mode bit decides how the request ends.
- **Latched interrupt mode:** the flag holds until the host reads the status register, and the read clears it. If the hold-off bit is set, the flag is never released sooner than four clocks (about 122 µs at 32.768 kHz) after it was raised. A read that comes earlier has its clear put off until that point.
- **Self-clearing pulse mode:** reads leave the flag alone. The flag clears when the host writes 0 to it, or when the selected tap reaches its half-period strobe, whichever comes first.

The host reaches three registers through a single address, write-enable and read-enable port. The flag bit always agrees with the pin: the pin is driven low exactly while the flag reads 1.

Top module: `rtc_periodic_req`

## Requirements
- R1: After reset, `req_n` is 1 and `req_oe` is 0. Address 0 (control) reads 4'b0001: mask=1, mode=0, hold-off=0. Address 1 (period select) reads 0. Address 2 (status) and address 3 read 0.
- R2: If `period_tick[sel]` is 1 on a clock edge while the mask is 0 and the flag is 0, the flag reads 1 and `req_n` is 0 from that edge on. Strobes on any other tap have no effect.
- R3: At all times the status bit 0, `req_oe` and `!req_n` carry the same value.
- R4: While control bit 0 (mask) is 1, no new request is raised. A request already pending still clears by the normal rules of its mode.
- R5: In interrupt mode (control bit 1 = 1) with hold-off off (control bit 2 = 0), the flag stays set until a read of address 2 (`rd_en`=1). The flag is clear after the edge that samples the read.
- R6: In interrupt mode with control bit 2 = 1, let the raise happen at edge E0. A read at edge Ek with k<4 clears the flag at E4. A read at k≥4 clears it at Ek.
- R7: In interrupt mode, a write to address 2 never clears the flag. A period strobe that arrives while the flag is set is ignored, and it does not restart the hold-off window.
- R8: In pulse mode (control bit 1 = 0), a read of address 2 leaves the flag set. A write of bit 0 = 0 to address 2 clears it at that edge, and a write of bit 0 = 1 has no effect.
- R9: In pulse mode, a `half_tick[sel]` strobe clears a set flag at that edge. Half strobes on other taps do not clear it.
- R10: The period-select code `sel` (address 1, bits 2:0) selects tap index `sel` of both strobe buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (32.768 kHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_tick | input | 8 | One-cycle period-expiry strobes, one per tap |
| half_tick | input | 8 | One-cycle half-period strobes, one per tap |
| addr | input | 2 | Register address (0 control, 1 period select, 2 status) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Register write data |
| rd_en | input | 1 | Register read strobe; a read of address 2 is a clear event |
| rd_data | output | 4 | Register read data for `addr`, combinational |
| req_n | output | 1 | Active-low request, 0 while the flag is set |
| req_oe | output | 1 | Output enable, 1 while `req_n` is driven low |

## Verification
The bound checker watches the flag's next-state rules on every cycle:
- a raise when the selected tap expires while unmasked;
- no raise while masked;
- the hold in interrupt mode until a read or a pending deferred clear;
- no release inside the hold-off window;
- the hold in pulse mode unless a 0 is written or the half strobe arrives;
- the immediate clear on a read when hold-off is off.

Other behaviours can only be shown by the bench's scenarios:
- the exact edge on which a deferred clear lands, for every read delay from 1 to 6 clocks with hold-off on and off;
- tap selection across all 64 select/tap pairs;
- the fact that a strobe during a pending request does not restart the hold-off window.

// File: rtl/prq_pkg.sv
package prq_pkg;
   // Register addresses
   localparam int ADDR_CTRL = 0;
   localparam int ADDR_PSEL = 1;
   localparam int ADDR_STAT = 2;
   // Control register bit positions
   localparam int BIT_MASK  = 0;
   localparam int BIT_MODE  = 1;
   localparam int BIT_HOLD  = 2;
   // Status register bit position
   localparam int BIT_FLAG  = 0;

   typedef struct packed {
      logic hold_en;
      logic irq_mode;
      logic mask;
   } prq_ctrl_t;

   localparam prq_ctrl_t CTRL_RESET = '{hold_en: 1'b0, irq_mode: 1'b0, mask: 1'b1};
endpackage

// File: rtl/prq_tap_select.sv
module prq_tap_select #(
   parameter int SEL_W = 3,
   localparam int NTAPS = 1 << SEL_W
) (
   input  logic [NTAPS-1:0] period_tick,
   input  logic [NTAPS-1:0] half_tick,
   input  logic [SEL_W-1:0] sel,
   output logic             expire,
   output logic             restore
);
   logic [NTAPS-1:0] sel_onehot;
   logic [NTAPS-1:0] exp_hit;
   logic [NTAPS-1:0] rst_hit;

   for (genvar i = 0; i < NTAPS; i++) begin : g_tap
      assign sel_onehot[i] = (sel == SEL_W'(i));
      assign exp_hit[i]    = sel_onehot[i] & period_tick[i];
      assign rst_hit[i]    = sel_onehot[i] & half_tick[i];
   end

   assign expire  = |exp_hit;
   assign restore = |rst_hit;
endmodule

// File: rtl/prq_hold_timer.sv
module prq_hold_timer #(
   parameter int HOLD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic set_pend,
   input  logic clr_pend,
   output logic mature,
   output logic pend
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (clr_pend) pend_q <= 1'b0;
      else if (set_pend) pend_q <= 1'b1;
   end
   assign pend = pend_q;

   if (HOLD_CYCLES <= 1) begin : g_no_window
      assign mature = 1'b1;
   end else begin : g_window
      localparam int CW = (HOLD_CYCLES <= 2) ? 1 : $clog2(HOLD_CYCLES);
      localparam logic [CW-1:0] AGE_LAST = CW'(HOLD_CYCLES - 1);
      logic [CW-1:0] age_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 age_q <= '0;
         else if (start)             age_q <= '0;
         else if (age_q != AGE_LAST) age_q <= age_q + 1'b1;
      end
      assign mature = (age_q == AGE_LAST);
   end
endmodule

// File: rtl/prq_flag_core.sv
module prq_flag_core (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic restore,
   input  logic mask,
   input  logic irq_mode,
   input  logic hold_en,
   input  logic rd_evt,
   input  logic wr0_evt,
   input  logic mature,
   input  logic pend,
   output logic flag,
   output logic raise,
   output logic set_pend,
   output logic clr_pend
);
   logic flag_q;
   logic irq_clr;
   logic pulse_clr;

   assign raise     = !flag_q && !mask && expire;
   assign irq_clr   = flag_q && irq_mode && (rd_evt || pend) && (!hold_en || mature);
   assign pulse_clr = flag_q && !irq_mode && (wr0_evt || restore);
   assign set_pend  = flag_q && irq_mode && rd_evt && hold_en && !mature;
   assign clr_pend  = !flag_q || !irq_mode || irq_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    flag_q <= 1'b0;
      else if (raise)                flag_q <= 1'b1;
      else if (irq_clr || pulse_clr) flag_q <= 1'b0;
   end
   assign flag = flag_q;
endmodule

// File: rtl/prq_regs.sv
module prq_regs
   import prq_pkg::*;
#(
   parameter int SEL_W  = 3,
   parameter int ADDR_W = 2,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              flag,
   output logic [DATA_W-1:0] rd_data,
   output prq_ctrl_t         ctrl,
   output logic [SEL_W-1:0]  sel,
   output logic              rd_evt,
   output logic              wr0_evt
);
   logic hit_ctrl, hit_psel, hit_stat;
   prq_ctrl_t ctrl_q;
   logic [SEL_W-1:0] sel_q;

   assign hit_ctrl = (addr == ADDR_W'(ADDR_CTRL));
   assign hit_psel = (addr == ADDR_W'(ADDR_PSEL));
   assign hit_stat = (addr == ADDR_W'(ADDR_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
         sel_q  <= '0;
      end else if (wr_en) begin
         if (hit_ctrl) begin
            ctrl_q.mask     <= wr_data[BIT_MASK];
            ctrl_q.irq_mode <= wr_data[BIT_MODE];
            ctrl_q.hold_en  <= wr_data[BIT_HOLD];
         end
         if (hit_psel) sel_q <= wr_data[SEL_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (hit_ctrl) begin
         rd_data[BIT_MASK] = ctrl_q.mask;
         rd_data[BIT_MODE] = ctrl_q.irq_mode;
         rd_data[BIT_HOLD] = ctrl_q.hold_en;
      end else if (hit_psel) begin
         rd_data[SEL_W-1:0] = sel_q;
      end else if (hit_stat) begin
         rd_data[BIT_FLAG] = flag;
      end
   end

   assign ctrl    = ctrl_q;
   assign sel     = sel_q;
   assign rd_evt  = rd_en && hit_stat;
   assign wr0_evt = wr_en && hit_stat && !wr_data[BIT_FLAG];
endmodule

// File: rtl/rtc_periodic_req.sv
module rtc_periodic_req
   import prq_pkg::*;
#(
   parameter int SEL_W       = 3,
   parameter int HOLD_CYCLES = 4,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<SEL_W)-1:0]   period_tick,
   input  logic [(1<<SEL_W)-1:0]   half_tick,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    wr_en,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    rd_en,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    req_n,
   output logic                    req_oe
);
   if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
      $error("SEL_W must lie in 1..6");
   end
   if (DATA_W < 3 || DATA_W < SEL_W) begin : g_bad_data
      $error("DATA_W must hold the control bits and the select field");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must reach three registers");
   end
   if (HOLD_CYCLES < 1 || HOLD_CYCLES > 256) begin : g_bad_hold
      $error("HOLD_CYCLES must lie in 1..256");
   end

   prq_ctrl_t        ctrl;
   logic [SEL_W-1:0] sel;
   logic expire, restore, rd_evt, wr0_evt;
   logic mature, pend, flag_q, raise, set_pend, clr_pend;
   logic ctrl_mask, ctrl_mode, ctrl_hold;

   assign ctrl_mask = ctrl.mask;
   assign ctrl_mode = ctrl.irq_mode;
   assign ctrl_hold = ctrl.hold_en;

   prq_regs #(.SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .flag(flag_q), .rd_data(rd_data), .ctrl(ctrl), .sel(sel),
      .rd_evt(rd_evt), .wr0_evt(wr0_evt)
   );

   prq_tap_select #(.SEL_W(SEL_W)) u_taps (
      .period_tick(period_tick), .half_tick(half_tick), .sel(sel),
      .expire(expire), .restore(restore)
   );

   prq_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk(clk), .rst_n(rst_n), .start(raise), .set_pend(set_pend),
      .clr_pend(clr_pend), .mature(mature), .pend(pend)
   );

   prq_flag_core u_core (
      .clk(clk), .rst_n(rst_n), .expire(expire), .restore(restore),
      .mask(ctrl_mask), .irq_mode(ctrl_mode), .hold_en(ctrl_hold),
      .rd_evt(rd_evt), .wr0_evt(wr0_evt), .mature(mature), .pend(pend),
      .flag(flag_q), .raise(raise), .set_pend(set_pend), .clr_pend(clr_pend)
   );

   assign req_n  = ~flag_q;
   assign req_oe = flag_q;
endmodule

// File: rtl/prq_checker.sv
module prq_checker (
   input logic clk,
   input logic rst_n,
   input logic flag,
   input logic mask,
   input logic irq_mode,
   input logic hold_en,
   input logic expire,
   input logic restore,
   input logic rd_evt,
   input logic wr0_evt,
   input logic pend,
   input logic mature
);
   p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !mask && expire) |=> flag);

   p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && mask) |=> !flag);

   p_int_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && irq_mode && !rd_evt && !pend) |=> flag);

   p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && irq_mode && rd_evt && !hold_en) |=> !flag);

   p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && irq_mode && hold_en && !mature) |=> flag);

   p_pulse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !irq_mode && !wr0_evt && !restore) |=> flag);

   p_pulse_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !irq_mode && restore) |=> !flag);
endmodule

bind rtc_periodic_req prq_checker u_chk (
   .clk(clk), .rst_n(rst_n), .flag(flag_q), .mask(ctrl_mask),
   .irq_mode(ctrl_mode), .hold_en(ctrl_hold), .expire(expire),
   .restore(restore), .rd_evt(rd_evt), .wr0_evt(wr0_evt),
   .pend(pend), .mature(mature)
);

// File: tb/rtc_periodic_req_tb.sv
module rtc_periodic_req_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] period_tick = '0;
   logic [7:0] half_tick = '0;
   logic [1:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [3:0] rd_data;
   logic       req_n, req_oe;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rtc_periodic_req u_dut (
      .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .half_tick(half_tick),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .req_n(req_n), .req_oe(req_oe)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [3:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd_stat();
      addr = 2'd2; rd_en = 1'b1;
      step();
      rd_en = 1'b0;
   endtask

   task automatic raise_tap(input int t);
      period_tick[t] = 1'b1;
      step();
      period_tick = '0;
   endtask

   task automatic half_tap(input int t);
      half_tick[t] = 1'b1;
      step();
      half_tick = '0;
   endtask

   // R3: pin and status bit must agree with the expected flag
   task automatic peek(input string tag, input bit exp);
      addr = 2'd2;
      #1;
      chk({tag, " R3 flag"}, int'(rd_data[0]), int'(exp));
      chk({tag, " R3 pins"}, int'({req_n, req_oe}), int'({~exp, exp}));
   endtask

   task automatic reg_rd(input string tag, input logic [1:0] a, input int exp);
      addr = a;
      #1;
      chk(tag, int'(rd_data), exp);
   endtask

   task automatic drop_flag();
      wr(2'd0, 4'b0001);   // masked pulse mode
      wr(2'd2, 4'b0000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek("R1 reset", 1'b0);
      reg_rd("R1 ctrl", 2'd0, 1);
      reg_rd("R1 psel", 2'd1, 0);
      reg_rd("R1 addr3", 2'd3, 0);

      // R2/R10 sweep of every select code against every tap
      wr(2'd0, 4'b0010);
      for (int s = 0; s < 8; s++) begin
         wr(2'd1, 4'(s));
         reg_rd("R10 psel readback", 2'd1, s);
         for (int t = 0; t < 8; t++) begin
            raise_tap(t);
            peek($sformatf("R2 R10 sel=%0d tap=%0d", s, t), t == s);
            if (t == s) begin
               rd_stat();
               peek("R5 read clears", 1'b0);
            end
         end
      end

      // R5/R6 read delay sweep, hold-off off and on
      wr(2'd1, 4'd0);
      for (int d = 0; d < 2; d++) begin
         for (int k = 1; k <= 6; k++) begin
            int clr_edge;
            wr(2'd0, d ? 4'b0110 : 4'b0010);
            raise_tap(0);
            peek("R6 raised", 1'b1);
            repeat (k - 1) step();
            rd_stat();
            clr_edge = (d && k < 4) ? 4 : k;
            for (int m = k; m <= 8; m++) begin
               peek($sformatf("R5 R6 hold=%0d rd=%0d edge=%0d", d, k, m), m < clr_edge);
               if (m < 8) step();
            end
         end
      end

      // R7 writes ignored, strobe during pending does not restart window
      wr(2'd0, 4'b0110);
      raise_tap(0);
      wr(2'd2, 4'b0000);
      peek("R7 write0 ignored", 1'b1);
      wr(2'd2, 4'b0001);
      peek("R7 write1 ignored", 1'b1);
      step(); step();
      raise_tap(0);          // edge E5, must be ignored
      peek("R7 strobe while set", 1'b1);
      rd_stat();             // E6: window long over, clears now
      peek("R7 window not restarted", 1'b0);

      // R4 mask blocks raise, pending still clears
      wr(2'd0, 4'b0011);
      raise_tap(0);
      peek("R4 masked strobe", 1'b0);
      wr(2'd0, 4'b0010);
      raise_tap(0);
      wr(2'd0, 4'b0011);
      peek("R4 pending under mask", 1'b1);
      rd_stat();
      peek("R4 pending clears by read", 1'b0);

      // R8 pulse mode: reads ignored, write 0 clears
      wr(2'd0, 4'b0000);
      wr(2'd1, 4'd2);
      raise_tap(2);
      for (int i = 0; i < 3; i++) begin
         rd_stat();
         peek("R8 read ignored", 1'b1);
      end
      wr(2'd2, 4'b0001);
      peek("R8 write1 ignored", 1'b1);
      wr(2'd2, 4'b0000);
      peek("R8 write0 clears", 1'b0);

      // R9 pulse mode: half strobe of selected tap clears
      raise_tap(2);
      half_tap(5);
      peek("R9 other half ignored", 1'b1);
      half_tap(2);
      peek("R9 selected half clears", 1'b0);
      drop_flag();
      peek("R9 idle after cleanup", 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule